// File: doc/BRIEF.md
# Trimmed One-Second Timebase

This block turns a 32.768 kHz clock-enable into a one-second pulse and a seconds-of-minute count, and corrects crystal drift digitally. The enable drives a free-running prescaler; each prescaler wrap steps a small period counter that clears when it meets the current period's compare value. With no correction, one second is 256 counts of 128 enables.

Drift is corrected once every N seconds by changing the compare value for a single period. The counter and the prescaler are never rewritten, so no partial prescaler phase is lost. A positive trim shortens the corrected period. A negative trim adds counts by following a full period with an extra short period that does not advance the seconds. Trim and interval are sampled only at period boundaries.

Top module: `trim_sec_timer`

## Requirements
- R1: The period counter advances once for every PRESCALE (default 128) clock cycles on which `tick_en` is high. Cycles with `tick_en` low advance nothing, so pulse spacing measured in enables does not depend on how the enables are spread in time.
- R2: With no correction, a period is 2^CNT_W (default 256) counts, that is 2^CNT_W × PRESCALE enables. `sec_pulse` is high for exactly one clock, in the cycle after the clock edge that samples the last enable of the period.
- R3: A corrected period with a non-negative trim t (0 to 2^CNT_W−1) lasts 2^CNT_W − t counts. At the maximum trim the period is one count long.
- R4: A corrected period with a negative trim −m (m from 1 to 2^CNT_W) is a full 2^CNT_W-count period that ends with a pulse, followed by an extra m-count period that ends with no pulse. The next pulse therefore comes 2^CNT_W + m counts after the corrected one.
- R5: `corr_every` = N > 0 corrects every N-th pulse period. Periods are counted from reset, the extra periods of R4 are not counted, and the first period after reset is always uncorrected. N = 0 turns correction off, and the trim then has no effect.
- R6: `sec_of_min` counts pulses from 0 to 59 and wraps to 0. `min_pulse` is high together with the `sec_pulse` on which it wraps, and at no other time.
- R7: A correction never resets or skips prescaler phase. Every pulse spacing in enables is an exact multiple of PRESCALE that follows from R2 to R4.
- R8: Values of `trim_cnt` and `corr_every` are sampled only at the clock edge that ends a period. A change made in the middle of a period has no effect on that period's length.
- R9: After a synchronous reset with `rst_n` low, `sec_pulse` and `min_pulse` are 0, `sec_of_min` is 0, and the first period is uncorrected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | One-cycle enable at the 32.768 kHz rate |
| trim_cnt | input | CNT_W+1 | Two's-complement trim in counts: positive speeds up, negative slows down |
| corr_every | input | INTV_W | Number of pulse periods between corrections; 0 disables correction |
| sec_pulse | output | 1 | One-clock pulse per second |
| sec_of_min | output | 6 | Seconds within the minute, 0 to 59 |
| min_pulse | output | 1 | High with the pulse on which the seconds wrap to 0 |

## Verification
The bench targets the trim extremes. The largest positive trim gives a one-count period, and a design that subtracts with the wrong width would either never match or wrap to a long period. The most negative trim needs an extra period as long as a whole nominal one, and an off-by-one there changes the stretched pulse gap. The bench also changes trim in the middle of periods, which catches a design that reads the inputs continuously and produces periods of the wrong length. It thins the enables to check that a design that counts clocks instead of enables fails, and it runs with N = 0 and N = 1 to catch an interval counter that is off by one. A design that lets the extra period advance the seconds shows up as a wrong `sec_of_min` and an extra pulse.

// File: rtl/trim_pkg.sv
// Package: shared types for the trimmed one-second timebase.
// Assumes: nothing; holds only the period classification.
package trim_pkg;
    // Kind of the period currently being counted.
    typedef enum logic [1:0] {
        PER_NOM   = 2'd0,  // nominal full period, ends with a pulse
        PER_FAST  = 2'd1,  // shortened correction period, ends with a pulse
        PER_SLOW  = 2'd2,  // full period that will be followed by an extra period
        PER_EXTRA = 2'd3   // extra period of a slowing correction, no pulse
    } per_kind_t;
endpackage

// File: rtl/trim_prescale.sv
// Module: free-running prescaler on the slow clock-enable.
// Does: produces a one-cycle step every PRESCALE asserted enables.
// Assumes: PRESCALE >= 2; its phase is never reset except by rst_n.
module trim_prescale #(
    parameter int PRESCALE = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic step
);
    localparam int PRE_W = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

    logic [PRE_W-1:0] pre_q;

    // Step fires on the enable that completes a prescaler cycle.
    assign step = en && (pre_q == PRE_LAST);

    // Advance the prescaler phase on every enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (en) begin
            pre_q <= step ? '0 : pre_q + PRE_W'(1);
        end
    end

    // R1: prescaler phase only moves on an enable
    a_r1_pre_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(pre_q));
endmodule

// File: rtl/trim_period.sv
// Module: period counter that clears on compare match.
// Does: counts prescaler steps from 0 up to cmp, then wraps to 0.
// Assumes: cmp only changes on the step that wraps the counter.
module trim_period #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [CNT_W-1:0] cmp,
    output logic             wrap,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] cnt_q;

    // Period ends on the step that meets the compare value.
    assign wrap = step && (cnt_q == cmp);
    assign cnt  = cnt_q;

    // Count steps, clearing on compare match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= wrap ? '0 : cnt_q + CNT_W'(1);
        end
    end

    // R1: without a prescaler step the count holds
    a_r1_cnt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(cnt_q));
endmodule

// File: rtl/trim_sched.sv
// Module: correction scheduler.
// Does: at each period boundary, decides the next period's compare value
//       and kind from the trim and the interval, and counts pulse periods
//       since the last correction.
// Assumes: trim is two's complement, CNT_W+1 bits; inputs are sampled on
//       wrap only.
module trim_sched
    import trim_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int INTV_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wrap,
    input  logic [CNT_W:0]    trim,
    input  logic [INTV_W-1:0] intv,
    output logic [CNT_W-1:0]  cmp,
    output logic              sec_adv
);
    localparam logic [CNT_W-1:0] FULL = '1;

    per_kind_t         kind_q, kind_n;
    logic [CNT_W-1:0]  cmp_q, cmp_n;
    logic [CNT_W-1:0]  extra_q, extra_n;
    logic [INTV_W-1:0] since_q, since_after;
    logic              due;
    logic [CNT_W-1:0]  trim_inv;

    // For either sign, the wanted compare value is the low bits inverted.
    assign trim_inv = ~trim[CNT_W-1:0];
    assign cmp      = cmp_q;
    assign sec_adv  = wrap && (kind_q != PER_EXTRA);

    // Work out the pulse-period count after this period and whether the next one is corrected.
    always_comb begin
        if (intv == '0) begin
            since_after = '0;
        end else if (kind_q == PER_EXTRA) begin
            since_after = since_q;
        end else if (kind_q == PER_NOM) begin
            since_after = since_q + INTV_W'(1);
        end else begin
            since_after = '0;
        end
        due = (intv != '0) && (since_after >= intv - INTV_W'(1));
    end

    // Choose the kind and compare value of the next period.
    always_comb begin
        kind_n  = PER_NOM;
        cmp_n   = FULL;
        extra_n = extra_q;
        if (kind_q == PER_SLOW) begin
            kind_n = PER_EXTRA;
            cmp_n  = extra_q;
        end else if (due) begin
            if (trim[CNT_W]) begin
                kind_n  = PER_SLOW;
                extra_n = trim_inv;
            end else begin
                kind_n = PER_FAST;
                cmp_n  = trim_inv;
            end
        end
    end

    // Load the next period's settings only at a boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q  <= PER_NOM;
            cmp_q   <= FULL;
            extra_q <= '0;
            since_q <= '0;
        end else if (wrap) begin
            kind_q  <= kind_n;
            cmp_q   <= cmp_n;
            extra_q <= extra_n;
            since_q <= since_after;
        end
    end

    // R8: compare value never changes inside a period
    a_r8_cmp_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(cmp_q));
    // R4: a slowing full period is always followed by an extra period
    a_r4_extra_after_slow: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && kind_q == PER_SLOW) |=> (kind_q == PER_EXTRA));
endmodule

// File: rtl/trim_seconds.sv
// Module: seconds-of-minute counter with registered pulses.
// Does: on each advance, raises a one-cycle second pulse and steps 0..59,
//       raising the minute pulse on the wrap.
// Assumes: advances are at least two cycles apart.
module trim_seconds #(
    parameter int SEC_W = 6,
    parameter int SEC_MOD = 60
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [SEC_W-1:0] sec,
    output logic             sec_pulse,
    output logic             min_pulse
);
    localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SEC_MOD - 1);

    logic [SEC_W-1:0] sec_q;
    logic             sp_q, mp_q;

    assign sec       = sec_q;
    assign sec_pulse = sp_q;
    assign min_pulse = mp_q;

    // Step the seconds and register both pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q <= '0;
            sp_q  <= 1'b0;
            mp_q  <= 1'b0;
        end else begin
            sp_q <= adv;
            mp_q <= adv && (sec_q == SEC_LAST);
            if (adv) begin
                sec_q <= (sec_q == SEC_LAST) ? '0 : sec_q + SEC_W'(1);
            end
        end
    end

    // R6: seconds stay within the minute
    a_r6_sec_range: assert property (@(posedge clk) disable iff (!rst_n)
        sec_q <= SEC_LAST);
    // R6: minute pulse only with a second pulse, at count zero
    a_r6_min_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        mp_q |-> (sp_q && sec_q == '0));
endmodule

// File: rtl/trim_sec_timer.sv
// Module: top of the trimmed one-second timebase.
// Does: prescaler -> compare-cleared period counter -> correction
//       scheduler -> seconds counter.
// Assumes: tick_en is a one-cycle enable; PRESCALE >= 2.
module trim_sec_timer #(
    parameter int PRESCALE = 128,
    parameter int CNT_W    = 8,
    parameter int INTV_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [CNT_W:0]    trim_cnt,
    input  logic [INTV_W-1:0] corr_every,
    output logic              sec_pulse,
    output logic [5:0]        sec_of_min,
    output logic              min_pulse
);
    logic             step;
    logic             wrap;
    logic             sec_adv;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cmp;

    trim_prescale #(.PRESCALE(PRESCALE)) u_pre (
        .clk(clk), .rst_n(rst_n), .en(tick_en), .step(step)
    );

    trim_period #(.CNT_W(CNT_W)) u_per (
        .clk(clk), .rst_n(rst_n), .step(step), .cmp(cmp),
        .wrap(wrap), .cnt(cnt)
    );

    trim_sched #(.CNT_W(CNT_W), .INTV_W(INTV_W)) u_sch (
        .clk(clk), .rst_n(rst_n), .wrap(wrap), .trim(trim_cnt),
        .intv(corr_every), .cmp(cmp), .sec_adv(sec_adv)
    );

    trim_seconds #(.SEC_W(6), .SEC_MOD(60)) u_sec (
        .clk(clk), .rst_n(rst_n), .adv(sec_adv), .sec(sec_of_min),
        .sec_pulse(sec_pulse), .min_pulse(min_pulse)
    );

    // R2: the counter never runs past the active compare value
    a_r2_cnt_le_cmp: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= cmp);
    // R2: the second pulse is exactly one cycle wide
    a_r2_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse |=> !sec_pulse);
endmodule

// File: tb/trim_sec_timer_test.sv
module trim_sec_timer_test;
    localparam int CLK_PERIOD = 10;
    localparam int P     = 4;
    localparam int CW    = 4;
    localparam int IW    = 8;
    localparam int M     = 1 << CW;
    localparam int WDOG  = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic [CW:0]   trim = '0;
    logic [IW-1:0] intv = '0;
    logic          sec_pulse;
    logic [5:0]    sec_of_min;
    logic          min_pulse;

    trim_sec_timer #(.PRESCALE(P), .CNT_W(CW), .INTV_W(IW)) uut (
        .clk(clk), .rst_n(rst_n), .tick_en(en), .trim_cnt(trim),
        .corr_every(intv), .sec_pulse(sec_pulse), .sec_of_min(sec_of_min),
        .min_pulse(min_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    string cur_req = "R9";
    int    en_div = 1;
    int    en_ph  = 0;

    // reference model state, in units of enables
    int ref_pos, ref_len, ref_kind, ref_since, ref_extra, ref_sec;
    bit ref_pulse, ref_min;
    int en_total = 0;
    int last_total = 0;
    int gaps[$];
    int pulse_total = 0;
    int min_total = 0;

    // enable pattern: one enable every en_div cycles
    always @(negedge clk) begin
        if (!rst_n) begin
            en = 1'b0;
        end else if (en_div <= 1) begin
            en = 1'b1;
        end else begin
            en_ph = (en_ph + 1) % en_div;
            en = (en_ph == 0);
        end
    end

    // behavioural reference, updated at each edge from the sampled inputs
    always @(posedge clk) begin
        int t;
        ref_pulse = 0;
        ref_min = 0;
        if (!rst_n) begin
            ref_pos = 0; ref_len = M * P; ref_kind = 0; ref_since = 0;
            ref_extra = 0; ref_sec = 0; en_total = 0;
        end else if (en) begin
            en_total++;
            ref_pos++;
            if (ref_pos == ref_len) begin
                ref_pos = 0;
                if (ref_kind != 3) begin
                    ref_pulse = 1;
                    if (ref_sec == 59) begin ref_sec = 0; ref_min = 1; end
                    else ref_sec++;
                end
                if (ref_kind == 2) begin
                    ref_kind = 3; ref_len = ref_extra * P; ref_since = 0;
                end else begin
                    if (ref_kind == 1) ref_since = 0;
                    else if (ref_kind == 0) ref_since++;
                    if (intv == 0) ref_since = 0;
                    if (intv != 0 && ref_since >= int'(intv) - 1) begin
                        t = $signed(trim);
                        if (t >= 0) begin ref_kind = 1; ref_len = (M - t) * P; end
                        else begin ref_kind = 2; ref_len = M * P; ref_extra = -t; end
                    end else begin
                        ref_kind = 0; ref_len = M * P;
                    end
                end
            end
        end
    end

    // compare outputs with the reference and log pulse gaps, away from the edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (sec_pulse !== ref_pulse || min_pulse !== ref_min || sec_of_min !== 6'(ref_sec)) begin
                fails++;
                if (fails < 30)
                    $display("FAIL %s t=%0t: pulse/min/sec actual %b/%b/%0d expected %b/%b/%0d",
                             cur_req, $time, sec_pulse, min_pulse, sec_of_min, ref_pulse, ref_min, ref_sec);
            end
            if (sec_pulse === 1'b1) begin
                gaps.push_back(en_total - last_total);
                last_total = en_total;
                pulse_total++;
            end
            if (min_pulse === 1'b1) min_total++;
        end
    end

    task automatic check(input string req, input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit has_gap(input int v);
        foreach (gaps[i]) if (gaps[i] == v) return 1;
        return 0;
    endfunction

    function automatic bit all_gaps(input int v);
        foreach (gaps[i]) if (gaps[i] != v) return 0;
        return 1;
    endfunction

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_up;
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * WDOG);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        finish_up();
    end

    initial begin
        // R9: reset state
        run(4);
        check("R9", sec_pulse == 0 && min_pulse == 0 && sec_of_min == 0, sec_of_min, 0);
        intv = 0; trim = 5'sd3;
        rst_n = 1'b1;

        // R5 / R2: correction disabled, trim ignored, nominal periods
        cur_req = "R5";
        run(4 * M * P + 10);
        check("R5", gaps.size() >= 4 && all_gaps(M * P), gaps.size(), 4);
        check("R2", has_gap(M * P), gaps.size() > 0 ? gaps[0] : -1, M * P);

        // R1 / R7: thinned enables keep the spacing in enables
        cur_req = "R1";
        gaps.delete();
        en_div = 3;
        run(3 * 3 * M * P);
        check("R1", gaps.size() >= 2 && all_gaps(M * P), gaps.size(), 2);
        en_div = 1;

        // R3: fast trim every second period
        cur_req = "R3";
        run(M * P + 5);
        gaps.delete();
        intv = 8'd2; trim = 5'sd3;
        run(8 * M * P);
        check("R3", has_gap((M - 3) * P), gaps.size(), (M - 3) * P);
        check("R7", has_gap(M * P), gaps.size(), M * P);

        // R4: slowing trim every third period
        cur_req = "R4";
        gaps.delete();
        intv = 8'd3; trim = -5'sd5;
        run(10 * M * P);
        check("R4", has_gap((M + 5) * P), gaps.size(), (M + 5) * P);

        // R4 boundary: most negative trim, every period
        gaps.delete();
        intv = 8'd1; trim = 5'b10000;
        run(6 * M * P);
        check("R4", has_gap(2 * M * P), gaps.size(), 2 * M * P);

        // R3 boundary: largest positive trim gives one-count periods
        cur_req = "R3";
        gaps.delete();
        trim = 5'sd15;
        run(3 * M * P);
        check("R3", has_gap(P), gaps.size(), P);

        // R8: trim and interval changed mid-period
        cur_req = "R8";
        for (int k = 0; k < 24; k++) begin
            run(23 + (k * 37) % 61);
            trim = 5'((k * 7) % 32);
            intv = 8'(1 + (k % 3));
        end
        check("R8", fails == 0, fails, 0);

        // R6: run past a minute wrap
        cur_req = "R6";
        intv = 0;
        run(61 * M * P);
        check("R6", min_total >= 1 && min_total == pulse_total / 60, min_total, pulse_total / 60);
        check("R6", pulse_total % 60 == int'(sec_of_min), sec_of_min, pulse_total % 60);

        finish_up();
    end
endmodule